// File: doc/BRIEF.md
# Dual-Target Level Interrupt Controller

This block gathers a set of level-sensitive interrupt sources and delivers them to two processor targets, called primary and secondary. Each target has its own cause register and its own enable mask. The raw sources are synchronized once and latched into both targets' cause registers. A target's interrupt line is raised while any cause bit is set and enabled in that target's mask.

Software acknowledges a line by writing 1 to its cause bit. Writing 0 leaves a bit unchanged. Because the two targets have separate masks, a source can be steered to one processor and kept away from the other. For the primary target, a combinational encoder reports the lowest-numbered pending source together with a valid flag.

All register access goes through a single-cycle bus. Writes take effect on the rising clock edge. Read data is combinational from the address.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After a synchronous reset, both cause registers and both mask registers read 0, both interrupt outputs are low and the encoder valid flag is low.
- R2: Byte offset 0x00 holds the primary cause, 0x04 the primary mask, 0x08 the secondary cause and 0x0C the secondary mask. A write to a mask offset replaces the whole mask, and reads return the current register contents.
- R3: A source held high from just after a rising edge shows up in both targets' cause bits after the third rising edge, and not after the first or second.
- R4: Writing to a cause offset clears exactly the bits written as 1 in that target only. Bits written as 0 keep their value, so writing all-ones clears every bit whose source is low.
- R5: If a source is still high when its cause bit is acknowledged, the set wins: the cause bit stays 1 and the target's output stays asserted if the line is enabled.
- R6: A target's interrupt output is high exactly when the bitwise AND of its cause and mask registers is nonzero, where a mask bit of 1 enables the line.
- R7: A line enabled in only one target's mask raises only that target's output.
- R8: The encoder gives the index (0 to 31) of the lowest set bit of the primary cause AND primary mask, with valid high. When that AND is zero, valid is low. The secondary target's state has no influence on the encoder.
- R9: Writing 0 to a target's mask and then all-ones to its cause leaves that target's output low, even while a source is still asserted.
- R10: Reads at any address other than the four mapped offsets, including 0x10 to 0x1C and addresses whose two low bits are nonzero, return 0. Writes there change no register.
- R11: A cause bit that has been set stays set after its source drops, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw level interrupt sources, asynchronous |
| bus_addr | input | 5 | Byte address of register access |
| bus_we | input | 1 | Write enable, sampled on rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pri_o | output | 1 | Primary target interrupt |
| irq_sec_o | output | 1 | Secondary target interrupt |
| pri_idx_o | output | 5 | Lowest pending primary source index |
| pri_valid_o | output | 1 | Primary encoder result is valid |

## Verification
A table of source and mask patterns exercises the outputs and the encoder. It includes a single lowest line, a single highest line, several lines under a partial mask, lines enabled only for the secondary target, fully masked floods, and masks that are exact complements of the sources. Together these patterns separate a wrong AND or OR, a wrong encoder priority direction, and leakage between the two targets. Directed sequences cover the remaining behaviour. They count edges to pin down the synchronizer latency, show that a bit stays latched after its source drops, and show that a 0 write leaves a cause bit alone. They also cover an acknowledge racing a still-active source, the quiesce sequence, and accesses to unmapped or misaligned addresses. Together these expose off-by-one latency, a reversed set/clear priority and loose address decoding.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  // Number of processor targets and spacing of their register pairs.
  localparam int NUM_TGT    = 2;
  localparam int TGT_STRIDE = 8;
  localparam int MASK_REL   = 4;

  // Byte offset of the cause register of target t.
  function automatic logic [7:0] cause_off(int t);
    return 8'(t * TGT_STRIDE);
  endfunction

  // Byte offset of the mask register of target t.
  function automatic logic [7:0] mask_off(int t);
    return 8'(t * TGT_STRIDE + MASK_REL);
  endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irq_tgt_bank.sv
module irq_tgt_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               ack_we,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] cause_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] clr_bits;

  // Only the bits written as 1 are cleared; an active source wins over the clear.
  assign clr_bits = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (cause_q & ~clr_bits) | src_lvl;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign pend  = cause_q & mask_q;
  assign irq_o = |pend;

endmodule

// File: rtl/irq_lsb_enc.sv
module irq_lsb_enc #(
  parameter int WIDTH = 32,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);

  // Walk from the top down so the lowest set bit is the last to win.
  always_comb begin
    idx   = '0;
    valid = |vec;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_pri_o,
  output logic               irq_sec_o,
  output logic [IDX_W-1:0]   pri_idx_o,
  output logic               pri_valid_o
);

  import irq_steer_pkg::*;

  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] cause_q [NUM_TGT];
  logic [NUM_SRC-1:0] mask_q  [NUM_TGT];
  logic [NUM_SRC-1:0] pend    [NUM_TGT];
  logic [NUM_TGT-1:0] irq_vec;
  logic [NUM_TGT-1:0] ack_sel;
  logic [NUM_TGT-1:0] mask_sel;

  // One synchronizer shared by both targets, so both see identical sampling.
  irq_src_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (2)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (src_i),
    .dout (src_sync)
  );

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign ack_sel[t]  = bus_addr == ADDR_W'(cause_off(t));
    assign mask_sel[t] = bus_addr == ADDR_W'(mask_off(t));

    irq_tgt_bank #(
      .NUM_SRC (NUM_SRC)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .src_lvl (src_sync),
      .ack_we  (bus_we && ack_sel[t]),
      .mask_we (bus_we && mask_sel[t]),
      .wdata   (bus_wdata[NUM_SRC-1:0]),
      .cause_q (cause_q[t]),
      .mask_q  (mask_q[t]),
      .pend    (pend[t]),
      .irq_o   (irq_vec[t])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (ack_sel[t])  bus_rdata = DATA_W'(cause_q[t]);
      if (mask_sel[t]) bus_rdata = DATA_W'(mask_q[t]);
    end
  end

  irq_lsb_enc #(
    .WIDTH (NUM_SRC)
  ) u_enc (
    .vec   (pend[0]),
    .idx   (pri_idx_o),
    .valid (pri_valid_o)
  );

  assign irq_pri_o = irq_vec[0];
  assign irq_sec_o = irq_vec[1];

endmodule

// File: rtl/irq_steer_ctrl_chk.sv
module irq_steer_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_sync,
  input logic [NUM_SRC-1:0] cause_a,
  input logic [NUM_SRC-1:0] cause_b,
  input logic [NUM_SRC-1:0] mask_a,
  input logic [NUM_SRC-1:0] mask_b,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_pri_o,
  input logic               irq_sec_o,
  input logic [IDX_W-1:0]   pri_idx_o,
  input logic               pri_valid_o
);

  import irq_steer_pkg::*;

  logic               wr_cause_a;
  logic               wr_mask_a;
  logic               addr_mapped;
  logic [NUM_SRC-1:0] below_idx;
  logic [NUM_SRC-1:0] wbits;

  assign wbits       = bus_wdata[NUM_SRC-1:0];
  assign wr_cause_a  = bus_we && (bus_addr == ADDR_W'(cause_off(0)));
  assign wr_mask_a   = bus_we && (bus_addr == ADDR_W'(mask_off(0)));
  assign addr_mapped = (bus_addr == ADDR_W'(cause_off(0))) || (bus_addr == ADDR_W'(mask_off(0))) ||
                       (bus_addr == ADDR_W'(cause_off(1))) || (bus_addr == ADDR_W'(mask_off(1)));
  assign below_idx   = ~({NUM_SRC{1'b1}} << pri_idx_o);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cause_a == '0 && cause_b == '0 && mask_a == '0 && mask_b == '0 &&
                    !irq_pri_o && !irq_sec_o && !pri_valid_o));

  assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_mask_a |=> (mask_a == $past(wbits)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    wr_cause_a |=> ((cause_a & $past(wbits) & ~$past(src_sync)) == '0));

  assert_set_wins_a_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((cause_a & $past(src_sync)) == $past(src_sync)));

  assert_set_wins_b_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((cause_b & $past(src_sync)) == $past(src_sync)));

  assert_sec_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_b == '0) |-> !irq_sec_o);

  assert_enc_valid_R8: assert property (@(posedge clk) disable iff (rst)
    pri_valid_o == irq_pri_o);

  assert_enc_lowest_R8: assert property (@(posedge clk) disable iff (rst)
    pri_valid_o |-> (cause_a[pri_idx_o] && mask_a[pri_idx_o] &&
                     ((cause_a & mask_a & below_idx) == '0)));

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    !addr_mapped |-> (bus_rdata == '0));

  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_cause_a |=> (($past(cause_a) & ~cause_a) == '0));

endmodule

bind irq_steer_ctrl irq_steer_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_sync    (src_sync),
  .cause_a     (cause_q[0]),
  .cause_b     (cause_q[1]),
  .mask_a      (mask_q[0]),
  .mask_b      (mask_q[1]),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq_pri_o   (irq_pri_o),
  .irq_sec_o   (irq_sec_o),
  .pri_idx_o   (pri_idx_o),
  .pri_valid_o (pri_valid_o)
);

// File: tb/irq_steer_ctrl_bench.sv
module irq_steer_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CA = 5'h00;
  localparam logic [4:0] A_MA = 5'h04;
  localparam logic [4:0] A_CB = 5'h08;
  localparam logic [4:0] A_MB = 5'h0C;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] ma;
    logic [31:0] mb;
    logic        ea;
    logic        eb;
    logic        ev;
    logic [4:0]  ei;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 5'd0},
    '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 5'd31},
    '{32'h0000_0F00, 32'h0000_0C00, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 5'd10},
    '{32'h0001_0010, 32'h0000_0000, 32'h0001_0000, 1'b0, 1'b1, 1'b0, 5'd0},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 5'd0},
    '{32'hA000_0000, 32'h5FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 5'd0},
    '{32'hFFFF_0000, 32'h00F0_F000, 32'h0000_FFFF, 1'b1, 1'b0, 1'b1, 5'd20},
    '{32'h0000_0006, 32'h0000_0004, 32'h0000_0002, 1'b1, 1'b1, 1'b1, 5'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pri_o;
  logic        irq_sec_o;
  logic [4:0]  pri_idx_o;
  logic        pri_valid_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_steer_ctrl u_irq_steer_ctrl (
    .clk         (clk),
    .rst         (rst),
    .src_i       (src_i),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_pri_o   (irq_pri_o),
    .irq_sec_o   (irq_sec_o),
    .pri_idx_o   (pri_idx_o),
    .pri_valid_o (pri_valid_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_CA, rv); check("R1 cause pri", rv, 32'h0);
    bus_rd(A_MA, rv); check("R1 mask pri", rv, 32'h0);
    bus_rd(A_CB, rv); check("R1 cause sec", rv, 32'h0);
    bus_rd(A_MB, rv); check("R1 mask sec", rv, 32'h0);
    check("R1 outputs", {29'h0, irq_pri_o, irq_sec_o, pri_valid_o}, 32'h0);

    // R2 register map
    bus_wr(A_MA, 32'h1234_5678);
    bus_wr(A_MB, 32'h9ABC_DEF0);
    bus_rd(A_MA, rv); check("R2 mask pri readback", rv, 32'h1234_5678);
    bus_rd(A_MB, rv); check("R2 mask sec readback", rv, 32'h9ABC_DEF0);
    bus_rd(A_CA, rv); check("R2 cause pri idle", rv, 32'h0);

    // Table walk: R6 outputs, R7 steering, R8 encoder, R3 capture in both targets
    for (int v = 0; v < NVEC; v++) begin
      src_i = '0;
      repeat (3) @(negedge clk);
      bus_wr(A_CA, 32'hFFFF_FFFF);
      bus_wr(A_CB, 32'hFFFF_FFFF);
      bus_wr(A_MA, VECS[v].ma);
      bus_wr(A_MB, VECS[v].mb);
      src_i = VECS[v].src;
      repeat (3) @(negedge clk);
      #1;
      check($sformatf("R6 irq pri vec%0d", v), {31'h0, irq_pri_o}, {31'h0, VECS[v].ea});
      check($sformatf("R7 irq sec vec%0d", v), {31'h0, irq_sec_o}, {31'h0, VECS[v].eb});
      check($sformatf("R8 valid vec%0d", v), {31'h0, pri_valid_o}, {31'h0, VECS[v].ev});
      if (VECS[v].ev)
        check($sformatf("R8 index vec%0d", v), {27'h0, pri_idx_o}, {27'h0, VECS[v].ei});
      bus_rd(A_CA, rv); check($sformatf("R3 cause pri vec%0d", v), rv, VECS[v].src);
      bus_rd(A_CB, rv); check($sformatf("R3 cause sec vec%0d", v), rv, VECS[v].src);
    end

    // R3 latency: clear everything, then raise bit 5 just after a rising edge
    src_i = '0;
    repeat (3) @(negedge clk);
    bus_wr(A_CA, 32'hFFFF_FFFF);
    bus_wr(A_CB, 32'hFFFF_FFFF);
    src_i = 32'h0000_0020;
    @(negedge clk);
    bus_rd(A_CA, rv); check("R3 not after one edge", rv, 32'h0);
    @(negedge clk);
    bus_rd(A_CA, rv); check("R3 not after two edges", rv, 32'h0);
    @(negedge clk);
    bus_rd(A_CA, rv); check("R3 set after three edges pri", rv, 32'h20);
    bus_rd(A_CB, rv); check("R3 set after three edges sec", rv, 32'h20);

    // R11 latching after the source drops
    src_i = '0;
    repeat (4) @(negedge clk);
    bus_rd(A_CA, rv); check("R11 latched pri", rv, 32'h20);
    bus_rd(A_CB, rv); check("R11 latched sec", rv, 32'h20);

    // R4 write-1 acknowledge
    bus_wr(A_CA, 32'h0000_0000);
    bus_rd(A_CA, rv); check("R4 zero write no effect", rv, 32'h20);
    bus_wr(A_CA, 32'h0000_0020);
    bus_rd(A_CA, rv); check("R4 ack clears pri", rv, 32'h0);
    bus_rd(A_CB, rv); check("R4 sec untouched", rv, 32'h20);
    bus_wr(A_CB, 32'hFFFF_FFFF);
    bus_rd(A_CB, rv); check("R4 all-ones clears sec", rv, 32'h0);

    // R5 ack while the source is still high
    bus_wr(A_MA, 32'h0000_0080);
    src_i = 32'h0000_0080;
    repeat (3) @(negedge clk);
    bus_wr(A_CA, 32'hFFFF_FFFF);
    bus_rd(A_CA, rv); check("R5 set wins over ack", rv, 32'h80);
    check("R5 output stays high", {31'h0, irq_pri_o}, 32'h1);

    // R9 quiesce with a source still asserted
    bus_wr(A_MA, 32'h0);
    bus_wr(A_CA, 32'hFFFF_FFFF);
    bus_wr(A_MB, 32'h0);
    bus_wr(A_CB, 32'hFFFF_FFFF);
    #1;
    check("R9 quiesce pri low", {31'h0, irq_pri_o}, 32'h0);
    check("R9 quiesce valid low", {31'h0, pri_valid_o}, 32'h0);
    check("R9 quiesce sec low", {31'h0, irq_sec_o}, 32'h0);

    // R10 unmapped and misaligned accesses
    src_i = '0;
    bus_wr(5'h10, 32'hFFFF_FFFF);
    bus_wr(5'h05, 32'hFFFF_FFFF);
    bus_wr(5'h0D, 32'hFFFF_FFFF);
    bus_rd(5'h10, rv); check("R10 read 0x10", rv, 32'h0);
    bus_rd(5'h05, rv); check("R10 read 0x05", rv, 32'h0);
    bus_rd(5'h1C, rv); check("R10 read 0x1C", rv, 32'h0);
    bus_rd(A_MA, rv); check("R10 mask pri unchanged", rv, 32'h0);
    bus_rd(A_MB, rv); check("R10 mask sec unchanged", rv, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule